// File: doc/BRIEF.md
# Serial Flash Read Engine

This block is the read side of a small serial flash device. It acts as a slave on a four-wire serial bus in clock mode 0 and answers two commands: a plain read and a fast read. The controller pulls the select line low, shifts in an 8-bit command code and a 24-bit start address with the most significant bit first, and then clocks data bytes out of the internal array. For the fast read, one ignored byte sits between the address and the data. The address steps up by one after each byte and wraps from the last location to zero, so a single command can stream the whole array.

All bus pins are sampled by a system clock that runs much faster than the serial clock. Two synchronizer stages and an edge detector turn the pins into one-cycle events. The array is a read-only store of 2^ADDR_W bytes, 128 KiB by default. Its contents come from a fixed address pattern, so that a simulation can check every byte without a load path. While the `busy` input is high, command codes are refused. The output has a separate drive-enable so that it can share a line with other devices.

Top module: `sfr_read_engine`

## Requirements
- R1: After reset, and whenever chip select is high, `so_oe` is 0. A command begins only on a high-to-low transition of `cs_n`. Serial clocks sent while `cs_n` is high produce no output.
- R2: Command code 0x03 (plain read) drives the first data bit on the falling SCK edge that follows the 32nd rising edge. Each byte is sent most significant bit first, one bit per falling edge, and `so` is stable between falling edges.
- R3: Command code 0x0B (fast read) takes exactly eight more rising edges after the address. The first data bit appears on the falling edge after the 40th rising edge.
- R4: The address is the 24 bits sampled on rising edges 9 to 32, most significant bit first. Only the low ADDR_W bits select a byte; bits 23 down to ADDR_W are ignored.
- R5: After each byte the address goes up by one, and output continues for as long as `cs_n` stays low.
- R6: After the byte at address 2^ADDR_W-1, the next byte sent is the one at address 0.
- R7: Values on `si` after the address phase (during the dummy byte and the data) do not change the output.
- R8: Any command code other than 0x03 or 0x0B keeps `so_oe` at 0 until `cs_n` rises. Bits clocked in after it are not decoded.
- R9: If `busy` is 1 when the eighth command bit is sampled, the command is refused and `so_oe` stays 0 until `cs_n` rises.
- R10: Raising `cs_n` at any point ends the command. The next falling edge of `cs_n` starts a new command normally.
- R11: `so_oe` is 0 while the command code, address and dummy bits are being received.
- R12: The byte at address a equals (a mod 256) XOR (floor(a/256) mod 256) XOR floor(a/65536) XOR 0x5A.
- R13: `so` and `so_oe` respond on the third rising edge of `clk` after the bus pin edge that causes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus pins |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the controller |
| si | input | 1 | Serial data into the block |
| busy | input | 1 | When high, command codes are refused |
| so | output | 1 | Serial data out of the block |
| so_oe | output | 1 | Drive enable for `so` (1 = drive, 0 = high impedance) |

## Verification
Every output change is due on the third `clk` rising edge after the SCK or chip-select pin edge that causes it. The bench drives pins only on falling `clk` edges. After each pin change it masks its comparison for four sampling points and then compares `so_oe`, and `so` when enabled, on every clock until the next pin change. A behavioural model computes, for each serial period, whether the output should be enabled and which bit of which array byte it should carry. The model takes these from the command code, the busy level, the start address and the wrap rule.

// File: rtl/sfr_pkg.sv
// Shared types and constants for the serial flash read engine.
// Assumes byte-wide data and a 24-bit address field on the bus.
package sfr_pkg;

    // Phases of one chip-select window
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGN
    } phase_t;

    localparam int          BYTE_W     = 8;
    localparam int          BUS_ADDR_W = 24;
    localparam logic [7:0]  CMD_READ   = 8'h03;
    localparam logic [7:0]  CMD_FAST   = 8'h0B;

    // Fixed array contents as a function of the address
    function automatic logic [BYTE_W-1:0] pattern_byte(input logic [BUS_ADDR_W-1:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

endpackage

// File: rtl/sfr_sync.sv
// Pin synchronizer with edge detection.
// Moves an asynchronous pin into the clk domain through STAGES flops.
// Gives one-cycle rise and fall strobes. Assumes the pin stays stable
// for several clk cycles between edges.
module sfr_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    // Shift the pin through the synchronizer and one history flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {CHAIN_W{RST_VAL}};
        end else begin
            chain <= {chain[CHAIN_W-2:0], pin};
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~chain[STAGES];
    assign fall  = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/sfr_ctrl.sv
// Command phase controller.
// Tracks the phase within one chip-select window and shifts in the
// command code and the address on rising serial clocks. Decides whether
// the command is a read. Assumes cs_fall and sck_rise never occur in the
// same cycle.
module sfr_ctrl
    import sfr_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DUMMY_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              si_s,
    input  logic              busy,
    output phase_t            phase,
    output logic              addr_ld,
    output logic [ADDR_W-1:0] ld_addr
);
    localparam int CNT_W = $clog2(BUS_ADDR_W);
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(BUS_ADDR_W - 1);
    localparam logic [CNT_W-1:0] DUM_LAST  = CNT_W'(DUMMY_BITS - 1);

    logic [BUS_ADDR_W-1:0] shreg;
    logic [CNT_W-1:0]      cnt;
    logic                  fast;

    logic [BUS_ADDR_W-1:0] sh_next;
    logic [BYTE_W-1:0]     code_now;
    logic                  code_ok;

    assign sh_next  = {shreg[BUS_ADDR_W-2:0], si_s};
    assign code_now = sh_next[BYTE_W-1:0];
    assign code_ok  = (code_now == CMD_READ) || (code_now == CMD_FAST);

    // The address is handed to the output stage on the last address bit
    assign addr_ld = (phase == ST_ADDR) && sck_rise && (cnt == ADDR_LAST);
    assign ld_addr = sh_next[ADDR_W-1:0];

    // Advance the phase and bit counter on bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            fast  <= 1'b0;
        end else if (cs_s) begin
            phase <= ST_IDLE;
        end else if (cs_fall) begin
            phase <= ST_OPC;
            cnt   <= '0;
        end else if (sck_rise) begin
            case (phase)
                ST_OPC: begin
                    shreg <= sh_next;
                    if (cnt == OPC_LAST) begin
                        cnt   <= '0;
                        fast  <= (code_now == CMD_FAST);
                        phase <= (busy || !code_ok) ? ST_IGN : ST_ADDR;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    shreg <= sh_next;
                    if (cnt == ADDR_LAST) begin
                        cnt   <= '0;
                        phase <= fast ? ST_DUMMY : ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_DUMMY: begin
                    if (cnt == DUM_LAST) begin
                        cnt   <= '0;
                        phase <= ST_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sfr_array.sv
// Read-only byte array of 2^ADDR_W locations.
// The contents are a fixed function of the address and the read is
// combinational. Assumes ADDR_W <= 24.
module sfr_array
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BYTE_W-1:0] data
);
    // Look up the byte at the requested location
    always_comb begin
        data = pattern_byte(BUS_ADDR_W'(addr));
    end
endmodule

// File: rtl/sfr_out.sv
// Output byte shifter and address pointer.
// Fetches a byte on the first falling clock of each byte and sends it MSB
// first, one bit per falling serial clock, then steps the pointer with
// wrap to zero. Assumes data_en drops as soon as chip select rises.
module sfr_out
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_en,
    input  logic              sck_fall,
    input  logic              addr_ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              so,
    output logic              so_oe
);
    localparam int BIT_W = $clog2(BYTE_W);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic [BIT_W-1:0]  bit_i;
    logic [BYTE_W-1:0] obyte;
    logic              fetch;

    assign fetch = data_en && sck_fall && (bit_i == '0);

    // Load the start address, then step it after every fetched byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr <= '0;
        end else if (addr_ld) begin
            rd_addr <= ld_addr;
        end else if (fetch) begin
            rd_addr <= (rd_addr == LAST_ADDR) ? '0 : rd_addr + 1'b1;
        end
    end

    // Drive one data bit per falling serial clock while in the data phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
            bit_i <= '0;
            obyte <= '0;
        end else if (!data_en) begin
            so_oe <= 1'b0;
            bit_i <= '0;
        end else if (sck_fall) begin
            so_oe <= 1'b1;
            bit_i <= bit_i + 1'b1;
            if (bit_i == '0) begin
                obyte <= rd_data;
                so    <= rd_data[BYTE_W-1];
            end else begin
                obyte <= {obyte[BYTE_W-2:0], 1'b0};
                so    <= obyte[BYTE_W-2];
            end
        end
    end
endmodule

// File: rtl/sfr_read_engine.sv
// Top of the serial flash read engine.
// Synchronizes the bus pins and runs the command phases, the read-only
// array and the output shifter. Assumes clk is at least eight times faster
// than sck and that the bus runs in clock mode 0.
module sfr_read_engine
    import sfr_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int SYNC_STAGE = 2,
    parameter int DUMMY_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    input  logic si,
    input  logic busy,
    output logic so,
    output logic so_oe
);
    logic              cs_s, cs_rise_unused, cs_fall;
    logic              sck_s, sck_rise, sck_fall;
    logic              si_s, si_rise_unused, si_fall_unused;
    phase_t            phase;
    logic              addr_ld;
    logic [ADDR_W-1:0] ld_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              data_en;
    logic              unused_ok;

    assign unused_ok = &{1'b0, cs_rise_unused, si_rise_unused, si_fall_unused, sck_s};

    sfr_sync #(.STAGES(SYNC_STAGE), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .pin(cs_n),
        .level(cs_s), .rise(cs_rise_unused), .fall(cs_fall)
    );

    sfr_sync #(.STAGES(SYNC_STAGE), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(rst_n), .pin(sck),
        .level(sck_s), .rise(sck_rise), .fall(sck_fall)
    );

    sfr_sync #(.STAGES(SYNC_STAGE), .RST_VAL(1'b0)) u_si_sync (
        .clk(clk), .rst_n(rst_n), .pin(si),
        .level(si_s), .rise(si_rise_unused), .fall(si_fall_unused)
    );

    sfr_ctrl #(.ADDR_W(ADDR_W), .DUMMY_BITS(DUMMY_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
        .sck_rise(sck_rise), .si_s(si_s), .busy(busy),
        .phase(phase), .addr_ld(addr_ld), .ld_addr(ld_addr)
    );

    sfr_array #(.ADDR_W(ADDR_W)) u_array (
        .addr(rd_addr), .data(rd_data)
    );

    // The data phase ends in the same cycle that chip select is seen high
    assign data_en = (phase == ST_DATA) && !cs_s;

    sfr_out #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst_n(rst_n), .data_en(data_en), .sck_fall(sck_fall),
        .addr_ld(addr_ld), .ld_addr(ld_addr), .rd_data(rd_data),
        .rd_addr(rd_addr), .so(so), .so_oe(so_oe)
    );
endmodule

// File: rtl/sfr_read_engine_chk.sv
// Property checker for the serial flash read engine, bound to the top.
// Watches the synchronized select, phase, pointer and output pins.
module sfr_read_engine_chk
    import sfr_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input phase_t            phase,
    input logic              sck_rise,
    input logic              sck_fall,
    input logic              busy,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              so,
    input logic              so_oe
);
    // R1: output released once select is seen high
    p_oe_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !so_oe);

    // R2: data bit only changes on a falling serial clock
    p_so_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (so_oe && !sck_fall) |=> $stable(so));

    // R5: pointer holds or steps by one (wrapping) during the data phase
    p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_DATA && !cs_s) |=>
            (rd_addr == $past(rd_addr)) || (rd_addr == ADDR_W'($past(rd_addr) + 1'b1)));

    // R8: a refused command stays refused while select is low
    p_ign_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IGN && !cs_s) |=> phase == ST_IGN);

    // R9: busy at the last code bit never leads into the address phase
    p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_OPC && sck_rise && busy) |=> phase != ST_ADDR);

    // R11: output drive only occurs in the data phase
    p_oe_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> phase == ST_DATA);
endmodule

bind sfr_read_engine sfr_read_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .phase(phase),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .busy(busy),
    .rd_addr(rd_addr), .so(so), .so_oe(so_oe)
);

// File: tb/sfr_read_engine_tb_top.sv
// Bench for the serial flash read engine: behavioural model compared every clock.
module sfr_read_engine_tb_top;
    localparam int H     = 8;
    localparam int DEPTH = 1 << 17;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0, busy = 1'b0;
    logic so, so_oe;

    int    total = 0, bad = 0, settle = 0;
    bit    chk_en = 1'b0;
    logic  exp_oe = 1'b0, exp_so = 1'b0;
    string tag = "R1";

    always #10 clk = ~clk;

    sfr_read_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .busy(busy), .so(so), .so_oe(so_oe)
    );

    // R12 content rule, written from the requirement
    function automatic logic [7:0] ref_byte(input int a);
        return 8'((a & 255) ^ ((a >> 8) & 255) ^ (a >> 16) ^ 90);
    endfunction

    // Compare on every clock once outputs have settled (R13: three edges)
    always @(posedge clk) begin
        #2;
        if (chk_en) begin
            if (settle > 0) begin
                settle--;
            end else begin
                total++;
                if (so_oe !== exp_oe) begin
                    bad++;
                    $display("FAIL %s: so_oe=%b expected %b at %0t", tag, so_oe, exp_oe, $time);
                end else if (exp_oe && so !== exp_so) begin
                    bad++;
                    $display("FAIL %s: so=%b expected %b at %0t", tag, so, exp_so, $time);
                end
            end
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One command window; stop_p < 0 runs to the end, sel = 0 keeps cs_n high
    task automatic run_cmd(input logic [7:0] op, input logic [23:0] a, input int nb,
                           input bit junk, input int stop_p, input bit sel, input string dtag);
        bit         valid;
        int         hdr, last_p, base, k;
        logic [7:0] cur;
        valid  = sel && !busy && (op == 8'h03 || op == 8'h0B);
        hdr    = (op == 8'h0B) ? 40 : 32;
        last_p = hdr - 1 + 8 * nb;
        base   = int'(a) % DEPTH;
        tag    = dtag;
        @(negedge clk);
        if (sel) begin
            cs_n = 1'b0;
            settle = 4;
        end
        hold(H);
        for (int p = 0; p < last_p; p++) begin
            if (p == stop_p) break;
            si = (p < 8) ? op[7-p] : (p < 32) ? a[31-p] : (junk ? (p[0] ^ p[1]) : 1'b0);
            tag = (valid && p < hdr - 1) ? "R11" : dtag;
            hold(H);
            sck = 1'b1; settle = 4;
            hold(H);
            sck = 1'b0; settle = 4;
            if (valid && p >= hdr - 1) begin
                k      = p - hdr + 1;
                cur    = ref_byte((base + k / 8) % DEPTH);
                exp_oe = 1'b1;
                exp_so = cur[7 - (k % 8)];
                tag    = dtag;
            end
        end
        hold(H);
        cs_n = 1'b1; settle = 4; exp_oe = 1'b0; tag = "R1";
        hold(2 * H);
    endtask

    initial begin
        hold(4);
        // R1 reset state
        total++;
        if (so_oe !== 1'b0) begin
            bad++;
            $display("FAIL R1: so_oe=%b expected 0 in reset", so_oe);
        end
        rst_n = 1'b1;
        hold(2);
        chk_en = 1'b1;

        run_cmd(8'h03, 24'h000010, 2, 1'b0, -1, 1'b0, "R1");      // clocks without select
        run_cmd(8'h03, 24'h000010, 3, 1'b0, -1, 1'b1, "R2 R5 R12");
        run_cmd(8'h0B, 24'h00ABCD, 2, 1'b0, -1, 1'b1, "R3");
        run_cmd(8'h03, 24'hFE1234, 2, 1'b0, -1, 1'b1, "R4");      // high bits ignored
        run_cmd(8'h0B, 24'h01FFFE, 4, 1'b0, -1, 1'b1, "R6");      // wrap to zero
        run_cmd(8'h03, 24'h000200, 2, 1'b1, -1, 1'b1, "R7");      // junk on si
        run_cmd(8'h0B, 24'h0155AA, 1, 1'b1, -1, 1'b1, "R7");
        run_cmd(8'h05, 24'h000000, 2, 1'b0, -1, 1'b1, "R8");      // unknown code
        run_cmd(8'h03, 24'h000033, 1, 1'b0, -1, 1'b1, "R8");
        busy = 1'b1;
        run_cmd(8'h03, 24'h000040, 2, 1'b0, -1, 1'b1, "R9");
        busy = 1'b0;
        run_cmd(8'h03, 24'h000041, 1, 1'b0, -1, 1'b1, "R9");
        run_cmd(8'h03, 24'h000077, 2, 1'b0, 20, 1'b1, "R10");     // cut in address
        run_cmd(8'h03, 24'h000078, 2, 1'b0, 35, 1'b1, "R10");     // cut in data
        run_cmd(8'h0B, 24'h000079, 1, 1'b0, -1, 1'b1, "R10");

        chk_en = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule